// File: doc/BRIEF.md
# Processor Bus Ownership Release Controller

This block sits on the bus side of a processor and decides on every clock who drives the address/parity lines and the data lines. External logic can take the bus back in three ways. An address-only hold frees the address lines so that another agent can drive snoop (inquire) cycles, while the data bus stays with the processor. A back-off frees the whole bus on the next clock, even in the middle of a cycle. An orderly hold frees the whole bus once the running cycle has ended, and confirms this with an acknowledge.

The controller drives the output-enable controls that the pad tristate buffers use. It also grants the start of a pending cache writeback. A writeback may run under an address-only hold, but it is deferred while a full-bus release is in force. A back-off that cuts a bus cycle short raises a one-clock restart pulse when the back-off ends. While any release is in force, an external address strobe captures the inquire address.

Top module: `bus_release_ctrl`

## Requirements
- R1: `addr_hold_i` is sampled on each rising edge. A sampled 1 drives `addr_oe_o` low after that edge, and a sampled 0 drives it high again after that edge, unless a full-bus release is in force.
- R2: An address-only hold leaves `data_oe_o` high.
- R3: `backoff_i` sampled high drives both `addr_oe_o` and `data_oe_o` low after that same edge, whatever the value of `cycle_busy_i`. They return high after the first edge at which `backoff_i` is sampled low.
- R4: While `cycle_busy_i` is 1, `hold_ack_o` does not rise. It rises after the first edge at which `hold_req_i` is 1, `cycle_busy_i` is 0 and `backoff_i` is 0. While `hold_ack_o` is 1, both enables are low.
- R5: `hold_ack_o` falls after the first edge at which `hold_req_i` is sampled 0. The enables come back at that same edge.
- R6: While back-off or hold acknowledge is active, `addr_hold_i` has no effect on `addr_oe_o` or `data_oe_o`.
- R7: While `clk_stopped_i` is 1, `addr_hold_i` is not sampled and the last sampled value is kept.
- R8: `wb_grant_o` = `wb_pending_i` AND NOT `cycle_busy_i` AND no back-off or hold acknowledge in force. An address-only hold does not block it.
- R9: If `backoff_i` is first sampled high while `cycle_busy_i` is 1, `restart_o` pulses high for one clock, after the edge at which `backoff_i` is sampled low again.
- R10: An edge with `ext_strobe_i` = 1 while `addr_oe_o` is low loads `addr_i` into `snoop_addr_o` and pulses `snoop_valid_o` for one clock. With `addr_oe_o` high, the strobe is ignored and `snoop_addr_o` keeps its value.
- R11: Reset gives `addr_oe_o` = 1, `data_oe_o` = 1, `hold_ack_o` = 0, `restart_o` = 0 and `snoop_valid_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_hold_i | input | 1 | Address-only hold request |
| backoff_i | input | 1 | Immediate full-bus back-off request |
| hold_req_i | input | 1 | Orderly full-bus hold request |
| wb_pending_i | input | 1 | Cache writeback waiting to start |
| cycle_busy_i | input | 1 | A bus cycle is in progress |
| clk_stopped_i | input | 1 | Controller is in the clock-stopped state |
| ext_strobe_i | input | 1 | External inquire address strobe |
| addr_i | input | ADDR_W | Address lines as seen from the pads |
| addr_oe_o | output | 1 | Output enable for address and parity lines |
| data_oe_o | output | 1 | Output enable for data lines |
| hold_ack_o | output | 1 | Hold acknowledge |
| wb_grant_o | output | 1 | Writeback may start |
| restart_o | output | 1 | Interrupted cycle must be rerun |
| snoop_addr_o | output | ADDR_W | Captured inquire address |
| snoop_valid_o | output | 1 | One-clock pulse on a new capture |

## Verification
The bench builds the block with `ADDR_W` = 16. At that width the capture patterns 0xA5C3 and 0x5A3C toggle every address bit both ways, and a single wrong bit in the snoop register shows up. The vector walk takes the block through the ownership sequences that matter: an address hold with a writeback, a hold held off by a busy cycle, a writeback deferred under hold, a back-off in mid-cycle followed by its restart pulse, and an address hold frozen in the clock-stopped state. Directed tests then cover capture and non-capture, and reset in the middle of a run.

// File: rtl/bus_rel_pkg.sv
package bus_rel_pkg;
  localparam int unsigned DEF_ADDR_W = 29;

  typedef enum logic {
    HOLD_IDLE    = 1'b0,
    HOLD_GRANTED = 1'b1
  } hold_state_e;
endpackage

// File: rtl/rel_sampler.sv
module rel_sampler (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic addr_hold_i,
  input  logic backoff_i,
  input  logic cycle_busy_i,
  input  logic clk_stopped_i,
  output logic ahold_o,
  output logic boff_o,
  output logic restart_o
);
  logic ahold_q, boff_q, intr_q, restart_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ahold_q   <= 1'b0;
      boff_q    <= 1'b0;
      intr_q    <= 1'b0;
      restart_q <= 1'b0;
    end else begin
      // no sampling while clock is stopped
      if (!clk_stopped_i) ahold_q <= addr_hold_i;
      boff_q    <= backoff_i;
      restart_q <= 1'b0;
      if (backoff_i && !boff_q && cycle_busy_i) intr_q <= 1'b1;
      else if (boff_q && !backoff_i) begin
        restart_q <= intr_q;
        intr_q    <= 1'b0;
      end
    end
  end

  assign ahold_o   = ahold_q;
  assign boff_o    = boff_q;
  assign restart_o = restart_q;

  p_stop_freeze_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_stopped_i |=> (ahold_q == $past(ahold_q)));

  p_restart_after_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_q |-> !backoff_i || $past(boff_q));
endmodule

// File: rtl/hold_fsm.sv
module hold_fsm
  import bus_rel_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_req_i,
  input  logic backoff_i,
  input  logic cycle_busy_i,
  output logic hold_ack_o
);
  hold_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      HOLD_IDLE:    if (hold_req_i && !cycle_busy_i && !backoff_i) state_d = HOLD_GRANTED;
      HOLD_GRANTED: if (!hold_req_i) state_d = HOLD_IDLE;
      default:      state_d = HOLD_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= HOLD_IDLE;
    else         state_q <= state_d;
  end

  assign hold_ack_o = (state_q == HOLD_GRANTED);

  p_wait_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_busy_i && !hold_ack_o) |=> !hold_ack_o);

  p_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_ack_o && !hold_req_i) |=> !hold_ack_o);
endmodule

// File: rtl/snoop_latch.sv
module snoop_latch #(
  parameter int unsigned ADDR_W = 29
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              released_i,
  input  logic              strobe_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              valid_o
);
  logic [ADDR_W-1:0] addr_q;
  logic              valid_q;
  logic              take;

  assign take = released_i && strobe_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= take;
      if (take) addr_q <= addr_i;
    end
  end

  assign addr_o  = addr_q;
  assign valid_o = valid_q;

  p_capture_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && !released_i) |=> (!valid_o && $stable(addr_o)));
endmodule

// File: rtl/bus_release_ctrl.sv
module bus_release_ctrl
  import bus_rel_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_hold_i,
  input  logic              backoff_i,
  input  logic              hold_req_i,
  input  logic              wb_pending_i,
  input  logic              cycle_busy_i,
  input  logic              clk_stopped_i,
  input  logic              ext_strobe_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              addr_oe_o,
  output logic              data_oe_o,
  output logic              hold_ack_o,
  output logic              wb_grant_o,
  output logic              restart_o,
  output logic [ADDR_W-1:0] snoop_addr_o,
  output logic              snoop_valid_o
);
  logic ahold, boff, hlda, full_rel;

  rel_sampler u_sampler (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .addr_hold_i  (addr_hold_i),
    .backoff_i    (backoff_i),
    .cycle_busy_i (cycle_busy_i),
    .clk_stopped_i(clk_stopped_i),
    .ahold_o      (ahold),
    .boff_o       (boff),
    .restart_o    (restart_o)
  );

  hold_fsm u_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hold_req_i  (hold_req_i),
    .backoff_i   (backoff_i),
    .cycle_busy_i(cycle_busy_i),
    .hold_ack_o  (hlda)
  );

  assign full_rel   = boff || hlda;
  assign addr_oe_o  = !(full_rel || ahold);
  assign data_oe_o  = !full_rel;
  assign hold_ack_o = hlda;
  // address-only hold does not block a writeback
  assign wb_grant_o = wb_pending_i && !cycle_busy_i && !full_rel;

  snoop_latch #(.ADDR_W(ADDR_W)) u_snoop (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .released_i(!addr_oe_o),
    .strobe_i  (ext_strobe_i),
    .addr_i    (addr_i),
    .addr_o    (snoop_addr_o),
    .valid_o   (snoop_valid_o)
  );

  p_addr_float_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_hold_i && !clk_stopped_i) |=> !addr_oe_o);

  p_data_kept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_hold_i && !backoff_i && !hold_req_i) |=> data_oe_o);

  p_backoff_next_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    backoff_i |=> (!addr_oe_o && !data_oe_o));

  p_hold_float_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_ack_o |-> (!addr_oe_o && !data_oe_o));

  p_wb_defer_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_ack_o || !data_oe_o) |-> !wb_grant_o);
endmodule

// File: tb/bus_release_ctrl_tb.sv
module bus_release_ctrl_tb;
  localparam int unsigned AW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ahold = 1'b0, boff = 1'b0, hold = 1'b0, wb = 1'b0, busy = 1'b0, stop = 1'b0, strobe = 1'b0;
  logic [AW-1:0] addr = '0;
  logic aoe, doe, hlda, grant, rst_o, sv;
  logic [AW-1:0] sa;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bus_release_ctrl #(.ADDR_W(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_hold_i(ahold), .backoff_i(boff),
    .hold_req_i(hold), .wb_pending_i(wb), .cycle_busy_i(busy),
    .clk_stopped_i(stop), .ext_strobe_i(strobe), .addr_i(addr),
    .addr_oe_o(aoe), .data_oe_o(doe), .hold_ack_o(hlda), .wb_grant_o(grant),
    .restart_o(rst_o), .snoop_addr_o(sa), .snoop_valid_o(sv)
  );

  // {ahold,boff,hold,busy,wb,stop} -> {aoe,doe,hlda,grant,restart}
  localparam logic [10:0] VEC [16] = '{
    11'b000000_11000, // idle, owned
    11'b100000_01000, // R1 address float
    11'b100010_01010, // R2 R8 writeback under address hold
    11'b000000_11000, // R1 back
    11'b001100_11000, // R4 busy delays ack
    11'b001000_00100, // R4 ack
    11'b001010_00100, // R8 deferred
    11'b101010_00100, // R6 address hold no effect
    11'b000010_11010, // R5 release, writeback granted
    11'b010100_00000, // R3 back-off mid cycle
    11'b010010_00000, // R8 deferred under back-off
    11'b000010_11011, // R9 restart, R3 release
    11'b100001_11000, // R7 not sampled while stopped
    11'b100000_01000, // R1 sampled again
    11'b000001_01000, // R7 kept while stopped
    11'b000000_11000  // R1 release
  };

  task automatic chk(input string req, input logic [AW-1:0] got, input logic [AW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #12;
    chk("R11 aoe", aoe, 1); chk("R11 doe", doe, 1); chk("R11 hlda", hlda, 0);
    chk("R11 restart", rst_o, 0); chk("R11 valid", sv, 0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      {ahold, boff, hold, busy, wb, stop} = VEC[i][10:5];
      step();
      chk($sformatf("R1-vec%0d aoe", i), aoe, VEC[i][4]);
      chk($sformatf("R2-vec%0d doe", i), doe, VEC[i][3]);
      chk($sformatf("R4-vec%0d hlda", i), hlda, VEC[i][2]);
      chk($sformatf("R8-vec%0d grant", i), grant, VEC[i][1]);
      chk($sformatf("R9-vec%0d restart", i), rst_o, VEC[i][0]);
    end

    // R10 capture during address hold
    @(negedge clk); ahold = 1'b1; step();
    @(negedge clk); strobe = 1'b1; addr = 16'hA5C3; step();
    chk("R10 valid", sv, 1); chk("R10 addr", sa, 16'hA5C3);
    @(negedge clk); strobe = 1'b0; step();
    chk("R10 pulse end", sv, 0);
    // capture under back-off
    @(negedge clk); ahold = 1'b0; boff = 1'b1; step();
    @(negedge clk); strobe = 1'b1; addr = 16'h5A3C; step();
    chk("R10 valid boff", sv, 1); chk("R10 addr boff", sa, 16'h5A3C);
    // R10 ignored while owned
    @(negedge clk); strobe = 1'b0; boff = 1'b0; step();
    chk("R9 no restart idle", rst_o, 0);
    @(negedge clk); strobe = 1'b1; addr = 16'hFFFF; step();
    chk("R10 ignored valid", sv, 0); chk("R10 ignored addr", sa, 16'h5A3C);
    @(negedge clk); strobe = 1'b0;

    // R11 reset mid-run during hold
    hold = 1'b1; step();
    chk("R4 ack pre-reset", hlda, 1);
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R11 hlda", hlda, 0); chk("R11 aoe2", aoe, 1); chk("R11 doe2", doe, 1);
    @(negedge clk); hold = 1'b0; rst_n = 1'b1; step();
    chk("R11 idle", aoe, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule